// File: doc/BRIEF.md
# Saturating Bit-Stream Wiper Stepper

This block adds a fast up/down mode to the serial control port of a 128-position digital potentiometer. A bus front end decodes the two-wire serial bus into one-cycle event strobes: start, stop, every SCL rising edge with the sampled SDA level, and every completed byte. The stepper watches those strobes. When a transaction opens with the alternate stepping identifier and the register byte that follows is zero, the block acknowledges both bytes and enters step mode. After that, every SCL clock moves the live wiper one position. A sampled 1 moves it up and a sampled 0 moves it down.

The wiper register sits outside the block. The block reads its current value on `wiper_pos`. For each accepted step it issues a one-cycle `step_up` or `step_dn` pulse together with the new position on `nxt_pos`, and the register loads that value. Steps stop at both ends of the range and never wrap. No acknowledge is requested while stepping. A stop condition ends the mode, and so does a new start condition. The position reached stays in the register.

Top module: `wiper_stepper`

## Requirements
- R1: A byte with bits [7:3] = 01011, bits [2:1] equal to `dev_pins` and bit 0 = 0 (write), received as the first byte after a start while `nv_busy` is low, is acknowledged by a one-cycle `ack_go` pulse in the cycle after its `byte_stb`.
- R2: A first byte with a different identifier, different pin bits, or bit 0 = 1 gets no `ack_go`. No step follows in that transaction.
- R3: After an accepted first byte, a second byte of 00h is acknowledged and enables step mode. Any other second byte gets no `ack_go`, and no step follows.
- R4: The SCL clock that carries the acknowledge of the second byte makes no step. In step mode, each later `bit_stb` with `bit_val` = 1 gives `step_up` and `nxt_pos` = position + 1 in the next cycle. With `bit_val` = 0 it gives `step_dn` and `nxt_pos` = position − 1.
- R5: At position 127 an up bit makes no pulse, and at position 0 a down bit makes no pulse. The position never wraps.
- R6: `bus_stop` ends step mode. Later bit strobes leave the position unchanged.
- R7: `bus_start` during step mode ends it and keeps the position. The bytes that follow are decoded as a fresh first byte.
- R8: In step mode no `ack_go` is issued, even on byte boundaries.
- R9: While `nv_busy` is high, the stepping first byte is not acknowledged and step mode is not entered.
- R10: After reset `ack_go`, `step_up`, `step_dn` and `step_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_pins | input | 2 | Device address select pins |
| nv_busy | input | 1 | Nonvolatile store in progress |
| bus_start | input | 1 | Start condition strobe |
| bus_stop | input | 1 | Stop condition strobe |
| bit_stb | input | 1 | Synchronised SCL rising-edge strobe |
| bit_val | input | 1 | SDA level sampled with `bit_stb` |
| byte_stb | input | 1 | Byte complete, coincident with its 8th `bit_stb` |
| byte_val | input | 8 | Byte just received, MSB first |
| wiper_pos | input | 7 | Current live wiper position |
| ack_go | output | 1 | Request an acknowledge for the byte just received |
| step_up | output | 1 | Wiper moved up one position |
| step_dn | output | 1 | Wiper moved down one position |
| nxt_pos | output | 7 | New wiper position, valid with a step pulse |
| step_mode | output | 1 | Step mode active |

## Verification
Step mode is driven with runs of all ones, runs of all zeros, and mixed bytes that carry their own byte strobe. These separate true per-bit stepping from byte-based decoding, and they confirm that byte boundaries bring no acknowledge. Long runs past both ends show saturation rather than wrapping. Headers with a wrong identifier, wrong pin bits, the read bit set, a non-zero register byte, or a busy store are each followed by step bits. This shows that every refusal is complete. A start condition in the middle of a run, followed by re-entry, shows that the position is kept and that the header is decoded anew.

// File: rtl/wstep_pkg.sv
package wstep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HACK,
        ST_REG,
        ST_RACK,
        ST_STEP
    } wstep_st_e;

endpackage

// File: rtl/wstep_hdr_match.sv
module wstep_hdr_match #(
    parameter int          ID_W    = 5,
    parameter logic [4:0]  ID_CODE = 5'b01011,
    parameter int          PIN_W   = 2
) (
    input  logic [7:0]       byte_val,
    input  logic [PIN_W-1:0] pins,
    output logic             hit
);
    localparam int BYTE_W = 8;
    localparam int ID_LSB = BYTE_W - ID_W;

    logic id_ok;
    logic pin_ok;
    logic wr_ok;

    always_comb begin
        id_ok  = (byte_val[BYTE_W-1:ID_LSB] == ID_CODE[ID_W-1:0]);
        pin_ok = (byte_val[PIN_W:1] == pins);
        wr_ok  = (byte_val[0] == 1'b0);
        hit    = id_ok && pin_ok && wr_ok;
    end

endmodule

// File: rtl/wstep_sat_step.sv
module wstep_sat_step #(
    parameter int POS_W = 7
) (
    input  logic [POS_W-1:0] pos,
    input  logic             dir_up,
    output logic             moved,
    output logic [POS_W-1:0] nxt
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;
    localparam logic [POS_W-1:0] ONE     = POS_W'(1);

    always_comb begin
        if (dir_up) begin
            moved = (pos != POS_MAX);
            nxt   = moved ? pos + ONE : pos;
        end else begin
            moved = (pos != POS_MIN);
            nxt   = moved ? pos - ONE : pos;
        end
    end

endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
    import wstep_pkg::*;
#(
    parameter int          POS_W    = 7,
    parameter int          PIN_W    = 2,
    parameter int          ID_W     = 5,
    parameter logic [4:0]  ID_CODE  = 5'b01011,
    parameter logic [7:0]  REG_ADDR = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] dev_pins,
    input  logic             nv_busy,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             byte_stb,
    input  logic [7:0]       byte_val,
    input  logic [POS_W-1:0] wiper_pos,
    output logic             ack_go,
    output logic             step_up,
    output logic             step_dn,
    output logic [POS_W-1:0] nxt_pos,
    output logic             step_mode
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] ONE     = POS_W'(1);

    typedef struct packed {
        wstep_st_e        st;
        logic             ack;
        logic             up;
        logic             dn;
        logic [POS_W-1:0] pos;
    } wstep_regs_t;

    wstep_regs_t q, d;

    logic             hdr_hit;
    logic             can_move;
    logic [POS_W-1:0] sat_pos;

    wstep_hdr_match #(
        .ID_W    (ID_W),
        .ID_CODE (ID_CODE),
        .PIN_W   (PIN_W)
    ) u_hdr (
        .byte_val (byte_val),
        .pins     (dev_pins),
        .hit      (hdr_hit)
    );

    wstep_sat_step #(
        .POS_W (POS_W)
    ) u_sat (
        .pos    (wiper_pos),
        .dir_up (bit_val),
        .moved  (can_move),
        .nxt    (sat_pos)
    );

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.up  = 1'b0;
        d.dn  = 1'b0;
        if (bus_stop) begin
            d.st = ST_IDLE;
        end else if (bus_start) begin
            d.st = ST_HDR;
        end else begin
            unique case (q.st)
                ST_HDR: begin
                    if (byte_stb) begin
                        if (hdr_hit && !nv_busy) begin
                            d.ack = 1'b1;
                            d.st  = ST_HACK;
                        end else begin
                            d.st  = ST_IDLE;
                        end
                    end
                end
                ST_HACK: begin
                    if (bit_stb) d.st = ST_REG;
                end
                ST_REG: begin
                    if (byte_stb) begin
                        if (byte_val == REG_ADDR) begin
                            d.ack = 1'b1;
                            d.st  = ST_RACK;
                        end else begin
                            d.st  = ST_IDLE;
                        end
                    end
                end
                ST_RACK: begin
                    if (bit_stb) d.st = ST_STEP;
                end
                ST_STEP: begin
                    if (bit_stb && can_move) begin
                        d.up  = bit_val;
                        d.dn  = !bit_val;
                        d.pos = sat_pos;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.ack <= 1'b0;
            q.up  <= 1'b0;
            q.dn  <= 1'b0;
            q.pos <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack_go    = q.ack;
    assign step_up   = q.up;
    assign step_dn   = q.dn;
    assign nxt_pos   = q.pos;
    assign step_mode = (q.st == ST_STEP);

    AST_UP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |-> ($past(wiper_pos) != POS_MAX) && (nxt_pos == $past(wiper_pos) + ONE)); // R5
    AST_DN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |-> ($past(wiper_pos) != '0) && (nxt_pos == $past(wiper_pos) - ONE)); // R5
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({step_up, step_dn}) <= 1); // R4
    AST_STEP_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> ($past(q.st) == ST_STEP) && $past(bit_stb)); // R4
    AST_NO_ACK_STEPPING: assert property (@(posedge clk) disable iff (!rst_n)
        step_mode |-> !ack_go); // R8
    AST_STOP_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !step_mode && !step_up && !step_dn); // R6
    AST_START_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (q.st == ST_HDR) && !step_up && !step_dn); // R7
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HDR && byte_stb && nv_busy) |=> !ack_go); // R9

endmodule

// File: tb/tb_wiper_stepper.sv
module tb_wiper_stepper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dev_pins = 2'b10;
    logic       nv_busy = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_val = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_val = 8'h00;
    logic [6:0] wiper_pos = 7'd64;
    logic       ack_go, step_up, step_dn, step_mode;
    logic [6:0] nxt_pos;

    int checks = 0;
    int fails  = 0;
    int acks   = 0;

    // reference model state
    int  md = 0;             // 0 idle,1 header,2 hdr ack clk,3 register,4 reg ack clk,5 stepping
    bit  e_ack = 0, e_up = 0, e_dn = 0;
    int  e_pos = 0;
    bit  model_on = 0;

    always #5 clk = ~clk;

    wiper_stepper dut (
        .clk(clk), .rst_n(rst_n), .dev_pins(dev_pins), .nv_busy(nv_busy),
        .bus_start(bus_start), .bus_stop(bus_stop), .bit_stb(bit_stb),
        .bit_val(bit_val), .byte_stb(byte_stb), .byte_val(byte_val),
        .wiper_pos(wiper_pos), .ack_go(ack_go), .step_up(step_up),
        .step_dn(step_dn), .nxt_pos(nxt_pos), .step_mode(step_mode)
    );

    // external live wiper register
    always @(posedge clk) begin
        if (step_up || step_dn) wiper_pos <= nxt_pos;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference, evaluated on each rising edge
    always @(posedge clk) begin
        int p;
        p = int'(wiper_pos);
        e_ack = 0; e_up = 0; e_dn = 0;
        if (!rst_n) begin
            md = 0;
        end else if (bus_stop) begin
            md = 0;
        end else if (bus_start) begin
            md = 1;
        end else if (md == 1 && byte_stb) begin
            if (byte_val[7:3] == 5'b01011 && byte_val[2:1] == dev_pins && !byte_val[0] && !nv_busy) begin
                e_ack = 1; md = 2;
            end else md = 0;
        end else if (md == 2 && bit_stb) begin
            md = 3;
        end else if (md == 3 && byte_stb) begin
            if (byte_val == 8'h00) begin e_ack = 1; md = 4; end
            else md = 0;
        end else if (md == 4 && bit_stb) begin
            md = 5;
        end else if (md == 5 && bit_stb) begin
            if (bit_val && p < 127) begin e_up = 1; e_pos = p + 1; end
            if (!bit_val && p > 0)  begin e_dn = 1; e_pos = p - 1; end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (ack_go) acks++;
        if (model_on) begin
            chk(ack_go == e_ack, "R1/R3/R8 ack_go", ack_go, e_ack);
            chk(step_up == e_up, "R4/R5 step_up", step_up, e_up);
            chk(step_dn == e_dn, "R4/R5 step_dn", step_dn, e_dn);
            chk(step_mode == (md == 5), "R6/R7 step_mode", step_mode, md == 5);
            if (e_up || e_dn) chk(int'(nxt_pos) == e_pos, "R4 nxt_pos", nxt_pos, e_pos);
        end
    end

    task automatic pulse_bit(input bit v, input bit last, input logic [7:0] b);
        @(negedge clk);
        bit_stb = 1; bit_val = v; byte_stb = last; byte_val = b;
        @(negedge clk);
        bit_stb = 0; byte_stb = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) pulse_bit(b[i], i == 0, b);
        pulse_bit(1'b0, 1'b0, 8'h00); // acknowledge clock
    endtask

    task automatic send_run(input bit v, input int n);
        for (int i = 0; i < n; i++) pulse_bit(v, 1'b0, 8'h00);
    endtask

    task automatic do_start();
        @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
    endtask

    task automatic do_stop();
        @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic enter_step();
        do_start();
        send_byte(8'h5C);
        send_byte(8'h00);
    endtask

    task automatic refused(input logic [7:0] h, input logic [7:0] r, input int exp_acks, input string tag);
        int a0, p0;
        a0 = acks; p0 = int'(wiper_pos);
        do_start();
        send_byte(h);
        send_byte(r);
        send_run(1'b1, 4);
        do_stop();
        chk(acks - a0 == exp_acks, tag, acks - a0, exp_acks);
        chk(int'(wiper_pos) == p0, tag, wiper_pos, p0);
    endtask

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        chk(!ack_go && !step_up && !step_dn && !step_mode, "R10 reset outputs",
            {ack_go, step_up, step_dn, step_mode}, 0);
        rst_n = 1;
        @(negedge clk);
        model_on = 1;

        // R1 R3 R4: entry and basic stepping
        a0 = acks;
        do_start();
        send_byte(8'h5C);
        chk(acks - a0 == 1, "R1 header ack", acks - a0, 1);
        send_byte(8'h00);
        chk(acks - a0 == 2, "R3 register ack", acks - a0, 2);
        chk(int'(wiper_pos) == 64, "R4 ack clock no step", wiper_pos, 64);
        send_run(1'b1, 3);
        chk(int'(wiper_pos) == 67, "R4 up run", wiper_pos, 67);
        send_run(1'b0, 5);
        chk(int'(wiper_pos) == 62, "R4 down run", wiper_pos, 62);
        send_byte(8'hF0); // 4 up, 4 down, ack clock 0 is one more down
        chk(int'(wiper_pos) == 61, "R4 mixed byte", wiper_pos, 61);
        chk(acks - a0 == 2, "R8 no ack while stepping", acks - a0, 2);
        do_stop();
        send_run(1'b1, 2);
        chk(int'(wiper_pos) == 61, "R6 stop holds", wiper_pos, 61);

        // R5 saturation at both ends
        enter_step();
        send_run(1'b1, 70);
        chk(int'(wiper_pos) == 127, "R5 top clamp", wiper_pos, 127);
        send_run(1'b0, 130);
        chk(int'(wiper_pos) == 0, "R5 bottom clamp", wiper_pos, 0);
        do_stop();

        // R2 refused headers
        refused(8'h5A, 8'h00, 0, "R2 wrong pins");
        refused(8'h5D, 8'h00, 0, "R2 read bit");
        refused(8'h54, 8'h00, 0, "R2 wrong id");
        // R3 wrong register byte
        refused(8'h5C, 8'h02, 1, "R3 bad register");
        // R9 busy store
        nv_busy = 1;
        refused(8'h5C, 8'h00, 0, "R9 busy refuse");
        nv_busy = 0;

        // R7 start in step mode
        enter_step();
        send_run(1'b1, 5);
        chk(int'(wiper_pos) == 5, "R7 before restart", wiper_pos, 5);
        do_start();
        send_run(1'b1, 3);
        chk(int'(wiper_pos) == 5, "R7 restart holds", wiper_pos, 5);
        do_start();
        a0 = acks;
        send_byte(8'h5C);
        send_byte(8'h00);
        chk(acks - a0 == 2, "R7 header reparsed", acks - a0, 2);
        send_run(1'b1, 2);
        chk(int'(wiper_pos) == 7, "R7 steps resume", wiper_pos, 7);
        do_stop();

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule